// File: doc/BRIEF.md
# Priority-Bit Row-Hit-First Request Scheduler

This block sits in front of one memory channel. It holds a few pending read or write requests and, whenever the channel is free, issues one of them. Each request names the core that made it, one of four banks, a row, and one urgency bit. Software sets the urgency bit for applications it has classified as very light memory users. The block keeps the open row of every bank and ranks candidates in three steps. Urgent requests come before all others. Among requests of equal urgency, those that hit the open row of their bank come before row misses. Among requests that are still tied, the oldest goes first. The urgency bit is the only per-application information the block holds.

Requests enter through a ready/valid handshake. An issued request occupies the channel for a fixed service time: a short one for a row hit, a longer one for a row miss. Its buffer slot is released when that time ends. Each issue appears on the output side as a one-cycle pulse. The pulse carries the request's fields and whether it was a row hit.

Top module: `mem_req_sched`

## Requirements
- R1: A candidate whose urgency bit (`in_urgent`, 1 = urgent) is set is issued before every candidate whose bit is clear, whatever their row status or age.
- R2: Among candidates of equal urgency, a row hit (its row equals the open row of its bank) is issued before a row miss, even when the miss arrived earlier.
- R3: When urgency and row status are equal, the request that was accepted earliest is issued first.
- R4: Each of the four banks keeps its own open row. After reset no bank has an open row, so the first request to any bank is a row miss.
- R5: Issuing a request makes its row the open row of its bank. `issue_hit` is 1 exactly when the row was already open at issue.
- R6: `in_ready` is 1 exactly when fewer than DEPTH requests are held. A request is stored only in a cycle where `in_valid` and `in_ready` are both 1. A request offered while `in_ready` is 0 is dropped and never issued.
- R7: With no held request waiting, `issue_valid` stays 0.
- R8: A row hit occupies the channel for HIT_LAT cycles (1) and a row miss for MISS_LAT cycles (3). The next issue comes no sooner than L+1 cycles after an issue of latency L. A waiting request is issued exactly at that point.
- R9: `issue_valid` is a single-cycle pulse. While it is high, `issue_core`, `issue_bank`, `issue_row` and `issue_urgent` carry the chosen request's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new request is offered |
| in_ready | output | 1 | The buffer has a free slot |
| in_core | input | CORE_W | Requesting core |
| in_bank | input | log2(NUM_BANKS) | Target bank |
| in_row | input | ROW_W | Target row |
| in_urgent | input | 1 | Request comes from a very-low-intensity application |
| issue_valid | output | 1 | One-cycle pulse: a request starts service |
| issue_core | output | CORE_W | Core of the issued request |
| issue_bank | output | log2(NUM_BANKS) | Bank of the issued request |
| issue_row | output | ROW_W | Row of the issued request |
| issue_urgent | output | 1 | Urgency bit of the issued request |
| issue_hit | output | 1 | The issued request hit the open row |

## Verification
The timing and occupancy checks assume that the upstream source obeys the handshake. A request counts only on a cycle where both valid and ready are high. They also assume that reset is held for at least one edge before traffic starts. The hit check compares each issue against a shadow of the rows opened by earlier issues, so it needs every issue to be observed from reset onward.

Two further assumptions bound the ordering logic. The oldest-first rule assumes no request waits while more than half of the arrival-number range of later requests goes past it. The directed stimulus stays within this: it never offers more than a handful of requests between drains. It tries an offer while the buffer is full only once, and then withdraws the offer.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {CH_IDLE = 1'b0, CH_BUSY = 1'b1} ch_state_e;

  // true when candidate a outranks candidate b: urgency, then row hit, then age
  function automatic logic outranks(input logic a_urg, input logic a_hit,
                                    input logic a_older,
                                    input logic b_urg, input logic b_hit);
    if (a_urg != b_urg) return a_urg;
    if (a_hit != b_hit) return a_hit;
    return a_older;
  endfunction

endpackage

// File: rtl/sched_open_rows.sv
module sched_open_rows #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int DEPTH     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_en,
  input  logic [BANK_W-1:0]             upd_bank,
  input  logic [ROW_W-1:0]              upd_row,
  input  logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   q_row,
  output logic [DEPTH-1:0]              q_hit
);

  logic [NUM_BANKS-1:0]            open_v;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_v <= '0;
    end else if (upd_en) begin
      open_v[upd_bank] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) open_row[upd_bank] <= upd_row;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lookup
    assign q_hit[g] = open_v[q_bank[g]] && (open_row[q_bank[g]] == q_row[g]);
  end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]             cand,
  input  logic [DEPTH-1:0]             urg,
  input  logic [DEPTH-1:0]             hit,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq,
  output logic                         any,
  output logic [IDX_W-1:0]             idx
);

  logic [SEQ_W-1:0] diff;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    diff = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i]) begin
        // wrap-safe age order: negative difference means entry i arrived first
        diff = seq[i] - seq[idx];
        if (!any || outranks(urg[i], hit[i], diff[SEQ_W-1], urg[idx], hit[idx])) begin
          idx = IDX_W'(i);
          any = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mem_req_sched.sv
module mem_req_sched
  import sched_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int NUM_BANKS = 4,
  parameter int CORE_W    = 3,
  parameter int ROW_W     = 8,
  parameter int SEQ_W     = 8,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LAT_MAX  = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT,
  localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CORE_W-1:0] in_core,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic              in_urgent,
  output logic              issue_valid,
  output logic [CORE_W-1:0] issue_core,
  output logic [BANK_W-1:0] issue_bank,
  output logic [ROW_W-1:0]  issue_row,
  output logic              issue_urgent,
  output logic              issue_hit
);

  logic [DEPTH-1:0]              slot_v;
  logic [DEPTH-1:0][CORE_W-1:0]  slot_core;
  logic [DEPTH-1:0][BANK_W-1:0]  slot_bank;
  logic [DEPTH-1:0][ROW_W-1:0]   slot_row;
  logic [DEPTH-1:0]              slot_urg;
  logic [DEPTH-1:0][SEQ_W-1:0]   slot_seq;
  logic [DEPTH-1:0]              slot_hit;
  logic [DEPTH-1:0]              cand;

  logic [SEQ_W-1:0] seq_ctr;
  logic [CNT_W-1:0] svc_cnt;
  logic [IDX_W-1:0] svc_idx;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic             accept;
  logic             start;
  ch_state_e        ch_state;

  assign ch_state = (svc_cnt != '0) ? CH_BUSY : CH_IDLE;
  assign in_ready = ~&slot_v;
  assign accept   = in_valid && in_ready;
  assign start    = (ch_state == CH_IDLE) && pick_any;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_v[i]) free_idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cand
    assign cand[g] = slot_v[g] && !((ch_state == CH_BUSY) && (svc_idx == IDX_W'(g)));
  end

  sched_open_rows #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .DEPTH     (DEPTH)
  ) rows_i (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (start),
    .upd_bank (slot_bank[pick_idx]),
    .upd_row  (slot_row[pick_idx]),
    .q_bank   (slot_bank),
    .q_row    (slot_row),
    .q_hit    (slot_hit)
  );

  sched_pick #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W)
  ) pick_i (
    .cand (cand),
    .urg  (slot_urg),
    .hit  (slot_hit),
    .seq  (slot_seq),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  // request payload storage: written on accept only, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      slot_core[free_idx] <= in_core;
      slot_bank[free_idx] <= in_bank;
      slot_row[free_idx]  <= in_row;
      slot_urg[free_idx]  <= in_urgent;
      slot_seq[free_idx]  <= seq_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v      <= '0;
      seq_ctr     <= '0;
      svc_cnt     <= '0;
      svc_idx     <= '0;
      issue_valid <= 1'b0;
    end else begin
      issue_valid <= start;
      if (start) begin
        svc_idx <= pick_idx;
        svc_cnt <= slot_hit[pick_idx] ? CNT_W'(HIT_LAT) : CNT_W'(MISS_LAT);
      end else if (ch_state == CH_BUSY) begin
        svc_cnt <= svc_cnt - 1'b1;
        if (svc_cnt == CNT_W'(1)) slot_v[svc_idx] <= 1'b0;
      end
      if (accept) begin
        slot_v[free_idx] <= 1'b1;
        seq_ctr          <= seq_ctr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      issue_core   <= slot_core[pick_idx];
      issue_bank   <= slot_bank[pick_idx];
      issue_row    <= slot_row[pick_idx];
      issue_urgent <= slot_urg[pick_idx];
      issue_hit    <= slot_hit[pick_idx];
    end
  end

endmodule

// File: rtl/mem_req_sched_chk.sv
module mem_req_sched_chk #(
  parameter int DEPTH     = 4,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LAT_MAX  = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT,
  localparam int SINCE_W  = $clog2(LAT_MAX + 3) + 1,
  localparam int HELD_W   = $clog2(DEPTH + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              issue_valid,
  input logic              issue_hit,
  input logic [BANK_W-1:0] issue_bank,
  input logic [ROW_W-1:0]  issue_row
);

  logic [NUM_BANKS-1:0]            sh_v;
  logic [NUM_BANKS-1:0][ROW_W-1:0] sh_row;
  logic [SINCE_W-1:0]              since;
  logic [SINCE_W-1:0]              prev_lat;
  logic                            have_prev;
  logic [SINCE_W-1:0]              rem;
  logic [HELD_W-1:0]               held;
  logic                            freed;
  logic                            took;
  logic [SINCE_W-1:0]              cur_lat;

  assign took    = in_valid && in_ready;
  assign cur_lat = issue_hit ? SINCE_W'(HIT_LAT) : SINCE_W'(MISS_LAT);
  assign freed   = issue_valid ? (cur_lat == SINCE_W'(1))
                               : (rem == SINCE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_v      <= '0;
      since     <= '0;
      prev_lat  <= '0;
      have_prev <= 1'b0;
      rem       <= '0;
      held      <= '0;
    end else begin
      if (issue_valid) begin
        sh_v[issue_bank]   <= 1'b1;
        sh_row[issue_bank] <= issue_row;
        since              <= SINCE_W'(1);
        prev_lat           <= cur_lat;
        have_prev          <= 1'b1;
        rem                <= (cur_lat == SINCE_W'(1)) ? '0 : cur_lat - 1'b1;
      end else begin
        if (since != '1) since <= since + 1'b1;
        if (rem != '0) rem <= rem - 1'b1;
      end
      held <= held + HELD_W'(took) - HELD_W'(freed);
    end
  end

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_ready == (held != HELD_W'(DEPTH)));                                   // R6

  AST_NO_IDLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> held != '0);                                             // R7

  AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (rst)
    issue_valid && have_prev |-> since >= prev_lat + 1'b1);                  // R8

  AST_HIT_TRUTH: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> issue_hit == (sh_v[issue_bank] && sh_row[issue_bank] == issue_row)); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> !issue_valid);                                           // R9

endmodule

bind mem_req_sched mem_req_sched_chk #(
  .DEPTH     (DEPTH),
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .HIT_LAT   (HIT_LAT),
  .MISS_LAT  (MISS_LAT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .issue_valid (issue_valid),
  .issue_hit   (issue_hit),
  .issue_bank  (issue_bank),
  .issue_row   (issue_row)
);

// File: tb/mem_req_sched_tb_top.sv
module mem_req_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_core = '0;
  logic [1:0] in_bank = '0;
  logic [7:0] in_row = '0;
  logic       in_urgent = 1'b0;
  logic       issue_valid;
  logic [2:0] issue_core;
  logic [1:0] issue_bank;
  logic [7:0] issue_row;
  logic       issue_urgent;
  logic       issue_hit;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n = 0;
  bit done = 1'b0;

  int rec_core [64];
  int rec_bank [64];
  int rec_row  [64];
  int rec_urg  [64];
  int rec_hit  [64];
  int rec_cyc  [64];

  always #4 clk = ~clk;

  mem_req_sched dut_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_core      (in_core),
    .in_bank      (in_bank),
    .in_row       (in_row),
    .in_urgent    (in_urgent),
    .issue_valid  (issue_valid),
    .issue_core   (issue_core),
    .issue_bank   (issue_bank),
    .issue_row    (issue_row),
    .issue_urgent (issue_urgent),
    .issue_hit    (issue_hit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && issue_valid && n < 64) begin
      rec_core[n] = issue_core;
      rec_bank[n] = issue_bank;
      rec_row[n]  = issue_row;
      rec_urg[n]  = issue_urgent;
      rec_hit[n]  = issue_hit;
      rec_cyc[n]  = cyc;
      n = n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int core, input int bank, input int row, input bit urg);
    in_core   = 3'(core);
    in_bank   = 2'(bank);
    in_row    = 8'(row);
    in_urgent = urg;
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_issue(input string req, input int k, input int core,
                              input int bank, input int row, input int urg, input int hit);
    check({req, " core"}, rec_core[k], core);
    check({req, " bank"}, rec_bank[k], bank);
    check({req, " row"},  rec_row[k],  row);
    check({req, " urg"},  rec_urg[k],  urg);
    check({req, " hit"},  rec_hit[k],  hit);
  endtask

  task automatic t_reset();
    check("R6 ready after reset", int'(in_ready), 1);
    check("R7 no issue after reset", int'(issue_valid), 0);
  endtask

  // blocker miss, then three contenders; buffer fills; one dropped offer
  task automatic t_urgent_first();
    push(0, 0, 5, 1'b0);
    push(1, 0, 5, 1'b0);
    push(2, 1, 9, 1'b1);
    push(3, 0, 5, 1'b0);
    check("R6 ready low when full", int'(in_ready), 0);
    in_core = 3'd7; in_bank = 2'd3; in_row = 8'd99; in_urgent = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (16) @(negedge clk);
    check("R9 count scenario1", n, 4);
    expect_issue("R4 first to empty bank is miss", 0, 0, 0, 5, 0, 0);
    expect_issue("R1 urgent first", 1, 2, 1, 9, 1, 0);
    expect_issue("R3 older hit", 2, 1, 0, 5, 0, 1);
    expect_issue("R3 younger hit", 3, 3, 0, 5, 0, 1);
    check("R8 gap after miss", rec_cyc[1] - rec_cyc[0], 4);
    check("R8 gap after urgent miss", rec_cyc[2] - rec_cyc[1], 4);
    check("R8 gap after hit", rec_cyc[3] - rec_cyc[2], 2);
  endtask

  task automatic t_hit_over_age();
    push(0, 2, 1, 1'b0);
    push(1, 3, 4, 1'b0);
    push(2, 1, 9, 1'b0);
    push(3, 0, 7, 1'b0);
    repeat (16) @(negedge clk);
    check("R9 count scenario2", n, 8);
    expect_issue("R4 blocker miss", 4, 0, 2, 1, 0, 0);
    expect_issue("R2 young hit first", 5, 2, 1, 9, 0, 1);
    expect_issue("R3 older miss", 6, 1, 3, 4, 0, 0);
    expect_issue("R3 younger miss", 7, 3, 0, 7, 0, 0);
  endtask

  task automatic t_open_rows();
    push(4, 0, 7, 1'b0);
    repeat (6) @(negedge clk);
    push(5, 0, 5, 1'b0);
    repeat (6) @(negedge clk);
    push(6, 2, 1, 1'b0);
    repeat (6) @(negedge clk);
    check("R9 count scenario3", n, 11);
    expect_issue("R5 row opened by miss", 8, 4, 0, 7, 0, 1);
    expect_issue("R5 changed row misses", 9, 5, 0, 5, 0, 0);
    expect_issue("R4 bank2 kept row", 10, 6, 2, 1, 0, 1);
  endtask

  task automatic t_idle();
    int seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (issue_valid) seen++;
    end
    check("R7 no issue when empty", seen, 0);
    check("R6 dropped offer never issued", n, 11);
    check("R6 ready when empty", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_urgent_first();
    t_hit_over_age();
    t_open_rows();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule